// File: doc/BRIEF.md
# Thread Fetch Eligibility Gate

This block sits in front of the fetch-thread selector of a multithreaded front end. On every cycle it looks at the status of each hardware thread and decides whether that thread may fetch. It also gives each thread a code that says why it was held back. The decision is combinational from the current per-thread inputs. The only state is a counter of cycles in which no thread could fetch.

A thread starts out blocked. It is released only if it clears a fixed chain of checks: thread running (or woken from suspension by a pending interrupt), fetch queue not really full, no fetch stall, no outstanding fault, and enough room in the fetch output buffer. The first failing check picks the cause code. A second pass then forces threads with zero priority to blocked. The all-blocked flag and the idle counter are taken from the result of that pass. The last pass forces threads under an issue-queue or reorder-buffer cap to blocked, as applied after thread selection.

Top module: `fetch_gate`

## Requirements
- R1: After reset the idle counter is 0. A thread that clears every check, has nonzero priority and has no cap shows blocked 0 and cause 0 (NONE).
- R2: A thread with `act_i` low that is not both suspended and interrupt-pending is blocked with cause 0 and has `wake_o` low.
- R3: A thread with `act_i` low, `susp_i` high and `irq_i` high raises `wake_o`. It is then judged by the remaining checks as if it were running.
- R4: The queue is full only when its total count equals QSIZE and its reserved count is below the total. This gives cause 1 (QFULL). A total of QSIZE made up only of reserved entries does not block.
- R5: A high `stall_i` gives cause 4 plus the thread's 3-bit stall sub-cause.
- R6: A nonzero fault count gives cause 3 (FAULT_FLUSH).
- R7: Free output-buffer slots below FETCH_W give cause 2 (IMISS). Exactly FETCH_W free slots does not block.
- R8: When several checks fail, the cause is taken from the first in the order: queue full, stall, fault, output buffer.
- R9: A thread with priority 0 is blocked. Its cause code keeps the value the check chain gave.
- R10: `all_blk_o` is high when every thread is blocked after the priority pass, with caps not counted. The idle counter adds one on each clock edge where `all_blk_o` is high, and wraps modulo 2^ICW.
- R11: An issue-queue cap or reorder-buffer cap forces the thread blocked. It changes neither its cause code nor `all_blk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | NTHR | Thread running |
| susp_i | input | NTHR | Thread suspended |
| irq_i | input | NTHR | Interrupt pending |
| q_total_i | input | NTHR*QCW | Fetch queue occupancy per thread |
| q_resv_i | input | NTHR*QCW | Reserved (miss) queue entries per thread |
| stall_i | input | NTHR | Fetch stall flag |
| stall_sub_i | input | NTHR*SCW | Stall sub-cause per thread |
| fault_cnt_i | input | NTHR*FCW | Outstanding fault count per thread |
| free_i | input | NTHR*SLW | Free output-buffer slots per thread |
| prio_i | input | NTHR*PW | Thread priority |
| iq_cap_i | input | NTHR | Issue-queue cap active |
| rob_cap_i | input | NTHR | Reorder-buffer cap active |
| blocked_o | output | NTHR | Final blocked bit per thread |
| cause_o | output | NTHR*CW | End-cause code per thread |
| wake_o | output | NTHR | Wake request for a suspended thread |
| all_blk_o | output | 1 | No thread eligible after the priority pass |
| idle_cnt_o | output | ICW | Idle cycle count |

## Verification
The bench targets a queue that is full only of reserved slots. A design that tested occupancy alone would report QFULL there and starve a thread that is waiting on a miss. It also drives free slots at exactly FETCH_W and one below, which catches an off-by-one in the buffer comparison. It drives threads that fail several checks at once, so a wrong check order shows up as the wrong cause code. Capped threads next to otherwise idle threads show whether a design wrongly lets caps move the all-blocked flag and the idle counter. The bench runs the counter narrow so that it wraps.

// File: rtl/fetch_gate.sv
module fetch_gate #(
  parameter int NTHR    = 4,
  parameter int QSIZE   = 8,
  parameter int FETCH_W = 4,
  parameter int SLW     = 4,
  parameter int SCW     = 3,
  parameter int FCW     = 4,
  parameter int PW      = 3,
  parameter int ICW     = 16,
  localparam int QCW    = $clog2(QSIZE + 1),
  localparam int CW     = $clog2(4 + (1 << SCW))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     act_i,
  input  logic [NTHR-1:0]     susp_i,
  input  logic [NTHR-1:0]     irq_i,
  input  logic [NTHR*QCW-1:0] q_total_i,
  input  logic [NTHR*QCW-1:0] q_resv_i,
  input  logic [NTHR-1:0]     stall_i,
  input  logic [NTHR*SCW-1:0] stall_sub_i,
  input  logic [NTHR*FCW-1:0] fault_cnt_i,
  input  logic [NTHR*SLW-1:0] free_i,
  input  logic [NTHR*PW-1:0]  prio_i,
  input  logic [NTHR-1:0]     iq_cap_i,
  input  logic [NTHR-1:0]     rob_cap_i,
  output logic [NTHR-1:0]     blocked_o,
  output logic [NTHR*CW-1:0]  cause_o,
  output logic [NTHR-1:0]     wake_o,
  output logic                all_blk_o,
  output logic [ICW-1:0]      idle_cnt_o
);
  localparam logic [CW-1:0] C_NONE  = CW'(0);
  localparam logic [CW-1:0] C_QFULL = CW'(1);
  localparam logic [CW-1:0] C_IMISS = CW'(2);
  localparam logic [CW-1:0] C_FLUSH = CW'(3);
  localparam logic [CW-1:0] C_STALL = CW'(4);

  logic [NTHR-1:0] sel_blk;
  logic [ICW-1:0]  idle_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [QCW-1:0] tot, rsv;
    logic [SCW-1:0] sub;
    logic [FCW-1:0] flt;
    logic [SLW-1:0] fre;
    logic [PW-1:0]  pri;
    logic [CW-1:0]  cs;
    logic           go, qfull, pass;

    assign tot = q_total_i[t*QCW +: QCW];
    assign rsv = q_resv_i[t*QCW +: QCW];
    assign sub = stall_sub_i[t*SCW +: SCW];
    assign flt = fault_cnt_i[t*FCW +: FCW];
    assign fre = free_i[t*SLW +: SLW];
    assign pri = prio_i[t*PW +: PW];

    assign wake_o[t] = ~act_i[t] & susp_i[t] & irq_i[t];
    assign go        = act_i[t] | wake_o[t];
    assign qfull     = (tot == QCW'(QSIZE)) && (rsv < tot);

    always_comb begin
      cs   = C_NONE;
      pass = 1'b0;
      if (!go)                        cs = C_NONE;
      else if (qfull)                 cs = C_QFULL;
      else if (stall_i[t])            cs = C_STALL + CW'(sub);
      else if (flt != '0)             cs = C_FLUSH;
      else if (fre < SLW'(FETCH_W))   cs = C_IMISS;
      else                            pass = 1'b1;
    end

    assign cause_o[t*CW +: CW] = cs;
    assign sel_blk[t]   = ~pass | (pri == '0);
    assign blocked_o[t] = sel_blk[t] | iq_cap_i[t] | rob_cap_i[t];

    a_r2_idle_thread_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_i[t] && !(susp_i[t] && irq_i[t])) |-> (blocked_o[t] && cause_o[t*CW +: CW] == C_NONE && !wake_o[t]));
    a_r9_prio_zero_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (pri == '0) |-> blocked_o[t]);
    a_r11_cap_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (iq_cap_i[t] || rob_cap_i[t]) |-> blocked_o[t]);
    a_r1_cause_implies_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_o[t*CW +: CW] != C_NONE) |-> blocked_o[t]);
    a_r4_reserved_only_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[t] && tot == QCW'(QSIZE) && rsv == tot) |-> (cause_o[t*CW +: CW] != C_QFULL));
  end

  assign all_blk_o  = &sel_blk;
  assign idle_cnt_o = idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         idle_q <= '0;
    else if (all_blk_o) idle_q <= idle_q + 1'b1;
  end

  a_r10_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    all_blk_o |=> (idle_cnt_o == ICW'($past(idle_cnt_o) + 1'b1)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !all_blk_o |=> $stable(idle_cnt_o));
  a_r11_all_blk_ignores_caps: assert property (@(posedge clk) disable iff (!rst_n)
    all_blk_o |-> (&blocked_o));
endmodule

// File: tb/fetch_gate_bench.sv
`timescale 1ns/1ps
module fetch_gate_bench;
  localparam int NT = 4, QSIZE = 8, FW = 4, SLW = 4, SCW = 3, FCW = 4, PW = 3, ICW = 3;
  localparam int QCW = $clog2(QSIZE + 1);
  localparam int CW  = $clog2(4 + (1 << SCW));

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [NT-1:0] act, susp, irq, stl, iqc, robc;
  logic [NT*QCW-1:0] tot, rsv;
  logic [NT*SCW-1:0] sub;
  logic [NT*FCW-1:0] flt;
  logic [NT*SLW-1:0] fre;
  logic [NT*PW-1:0]  pri;
  logic [NT-1:0]     blk, wake;
  logic [NT*CW-1:0]  cause;
  logic              allb;
  logic [ICW-1:0]    idle;

  fetch_gate #(.NTHR(NT), .QSIZE(QSIZE), .FETCH_W(FW), .SLW(SLW), .SCW(SCW),
               .FCW(FCW), .PW(PW), .ICW(ICW)) u_fetch_gate (
    .clk(clk), .rst_n(rst_n), .act_i(act), .susp_i(susp), .irq_i(irq),
    .q_total_i(tot), .q_resv_i(rsv), .stall_i(stl), .stall_sub_i(sub),
    .fault_cnt_i(flt), .free_i(fre), .prio_i(pri), .iq_cap_i(iqc), .rob_cap_i(robc),
    .blocked_o(blk), .cause_o(cause), .wake_o(wake), .all_blk_o(allb), .idle_cnt_o(idle));

  int m_act[NT], m_susp[NT], m_irq[NT], m_tot[NT], m_rsv[NT], m_stl[NT], m_sub[NT];
  int m_flt[NT], m_fre[NT], m_pri[NT], m_iq[NT], m_rob[NT];
  int n_run = 0, n_fail = 0, model_idle = 0;
  bit done = 0;

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive();
    for (int t = 0; t < NT; t++) begin
      act[t] = m_act[t][0]; susp[t] = m_susp[t][0]; irq[t] = m_irq[t][0];
      stl[t] = m_stl[t][0]; iqc[t] = m_iq[t][0]; robc[t] = m_rob[t][0];
      tot[t*QCW +: QCW] = QCW'(m_tot[t]); rsv[t*QCW +: QCW] = QCW'(m_rsv[t]);
      sub[t*SCW +: SCW] = SCW'(m_sub[t]); flt[t*FCW +: FCW] = FCW'(m_flt[t]);
      fre[t*SLW +: SLW] = SLW'(m_fre[t]); pri[t*PW +: PW] = PW'(m_pri[t]);
    end
  endtask

  task automatic set_pass(input int t);
    m_act[t] = 1; m_susp[t] = 0; m_irq[t] = 0; m_tot[t] = 0; m_rsv[t] = 0;
    m_stl[t] = 0; m_sub[t] = 0; m_flt[t] = 0; m_fre[t] = FW; m_pri[t] = 1;
    m_iq[t] = 0; m_rob[t] = 0;
  endtask

  task automatic set_rand(input int t);
    m_act[t]  = ($urandom % 4) != 0;
    m_susp[t] = $urandom % 2;
    m_irq[t]  = $urandom % 2;
    m_tot[t]  = ($urandom % 3 == 0) ? QSIZE : $urandom % (QSIZE + 1);
    m_rsv[t]  = ($urandom % 2) ? m_tot[t] : $urandom % (m_tot[t] + 1);
    m_stl[t]  = ($urandom % 6) == 0;
    m_sub[t]  = $urandom % 8;
    m_flt[t]  = ($urandom % 5 == 0) ? 1 + $urandom % 15 : 0;
    m_fre[t]  = ($urandom % 4 == 0) ? FW - 1 + $urandom % 2 : FW + $urandom % (16 - FW);
    m_pri[t]  = ($urandom % 5 == 0) ? 0 : 1 + $urandom % 7;
    m_iq[t]   = ($urandom % 8) == 0;
    m_rob[t]  = ($urandom % 8) == 0;
  endtask

  // One cycle: drive at negedge, compare 1 ns later, account for the edge in between.
  task automatic step();
    int all_exp = 1;
    drive();
    #1;
    for (int t = 0; t < NT; t++) begin
      int ec = 0, sel = 1, nfail = 0;
      bit go, wk, qf, fl, im;
      string tag = "R1";
      wk = !m_act[t] && m_susp[t] && m_irq[t];
      go = m_act[t] || wk;
      qf = (m_tot[t] == QSIZE) && (m_rsv[t] < m_tot[t]);
      fl = m_flt[t] != 0;
      im = m_fre[t] < FW;
      nfail = int'(qf) + int'(m_stl[t] != 0) + int'(fl) + int'(im);
      if (!go) tag = "R2";
      else if (qf) begin ec = 1; tag = "R4"; end
      else if (m_stl[t] != 0) begin ec = 4 + m_sub[t]; tag = "R5"; end
      else if (fl) begin ec = 3; tag = "R6"; end
      else if (im) begin ec = 2; tag = "R7"; end
      else sel = 0;
      if (go && nfail > 1) tag = "R8";
      if (m_pri[t] == 0) begin sel = 1; if (ec == 0) tag = "R9"; end
      if (sel == 0) all_exp = 0;
      chk({tag, " cause"}, int'(cause[t*CW +: CW]), ec);
      chk((m_iq[t] || m_rob[t]) ? "R11 blocked" : {tag, " blocked"}, int'(blk[t]),
          (sel || m_iq[t] || m_rob[t]) ? 1 : 0);
      chk("R3 wake", int'(wake[t]), int'(wk));
    end
    chk("R10 all_blk", int'(allb), all_exp);
    chk("R10 idle count", int'(idle), model_idle);
    @(negedge clk);
    if (all_exp != 0) model_idle = (model_idle + 1) % (1 << ICW);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) set_pass(t);
    drive();
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(idle), 0);
    rst_n = 1;
    // all threads eligible
    step();
    // reserved-only full queue passes; occupied full queue blocks
    m_tot[0] = QSIZE; m_rsv[0] = QSIZE;
    m_tot[1] = QSIZE; m_rsv[1] = QSIZE - 1;
    m_fre[2] = FW - 1; m_fre[3] = FW;
    step();
    // order: stall and fault and low buffer together
    for (int t = 0; t < NT; t++) set_pass(t);
    m_stl[0] = 1; m_sub[0] = 7; m_flt[0] = 2; m_fre[0] = 0;
    m_flt[1] = 5; m_fre[1] = 1;
    m_act[2] = 0; m_susp[2] = 1; m_irq[2] = 1;
    m_act[3] = 0; m_susp[3] = 1; m_irq[3] = 0;
    step();
    // caps on the only eligible threads: all_blk stays low
    for (int t = 0; t < NT; t++) set_pass(t);
    m_pri[0] = 0; m_pri[1] = 0; m_iq[2] = 1; m_rob[3] = 1;
    step();
    // every thread idle for enough cycles to wrap the counter
    for (int t = 0; t < NT; t++) m_act[t] = 0;
    repeat (10) step();
    for (int i = 0; i < 1500; i++) begin
      for (int t = 0; t < NT; t++) set_rand(t);
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule